// File: doc/BRIEF.md
# Extended branch and call resolver

This block settles one branch instruction once its fields are decoded. From the status flags, an opcode condition index and an 8-bit extension byte, it decides whether the branch is taken. It then forms the target address from a selectable base register plus a signed offset. It can also save the current program counter on the stack before jumping, and it can load the real target from memory through a pointer. It drives a simple single-cycle memory port with a 32-bit address and 16-bit data words. When it finishes, it returns the new program counter and stack pointer.

One branch opcode can therefore act as a plain flag test, a signed or unsigned compare branch, an unconditional or never-taken branch, a register-relative jump, a jump through a memory pointer, or a subroutine call. The surrounding core pulses `start_i` with all operands valid. It waits for `done_o`, then writes `pc_o` and `sp_o` back to its registers. Instruction fetch, offset extraction and interrupt handling stay outside.

Top module: `branch_resolver`

## Requirements
- R1: With extension bit 7 clear, `cond_sel_i` picks the flag test: 0 N clear, 1 N set, 2 V clear, 3 V set, 4 C clear, 5 C set, 6 Z clear, 7 Z set.
- R2: With extension bit 7 set, `cond_sel_i` picks: 0 N==V, 1 N!=V, 2 Z or N!=V, 3 not Z and N==V, 4 not C or Z, 5 C and not Z, 6 never, 7 always.
- R3: The base register number is 15 XOR extension bits [3:0]. Register k sits in `regs_i[32k+31:32k]`, register 15 is the PC and register 14 is the SP. A taken branch with extension bits 5 and 4 clear returns base + offset (modulo 2^32) on `pc_o`.
- R4: With extension bit 5 set, a taken branch reads 16-bit words at base+offset and then base+offset+1. The first read is the low half, and `pc_o` = {second, first}.
- R5: With extension bit 4 set, a taken branch first writes PC[31:16] at SP and then PC[15:0] at SP-1. It returns `sp_o` = SP-2, decrementing across page boundaries with the full 32-bit width.
- R6: A branch not taken makes no memory access. It raises `done_o` in the cycle after `start_i`, with `taken_o` low, `pc_o` = PC and `sp_o` = SP.
- R7: `done_o` is high for exactly one cycle. A taken branch finishes one cycle after start plus one cycle per memory access. All pushes come before all pointer reads.
- R8: After reset, `done_o`, `mem_we_o` and `mem_re_o` are low and `pc_o` and `sp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; operands sampled with it |
| cond_sel_i | input | 3 | Condition index from the opcode |
| ext_i | input | 8 | Bit 7 alternate set, 6 reserved, 5 indirect, 4 link, 3:0 base register select |
| offset_i | input | 32 | Signed branch offset |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| regs_i | input | 512 | Sixteen 32-bit registers, register k at bits 32k+31:32k |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe; data returned in the same cycle |
| mem_rdata_i | input | 16 | Read data |
| done_o | output | 1 | Completion pulse |
| taken_o | output | 1 | Branch was taken, valid with done_o |
| pc_o | output | 32 | New program counter |
| sp_o | output | 32 | New stack pointer |

## Verification
A wrong condition decode shows at once. In the cycle after start, `taken_o` has the wrong value and `pc_o` holds the target instead of the PC, or the reverse. A bad word index or a bad stack-pointer step shows on the memory port during the cycle of the faulty access: a wrong address, a swapped half, or a write after a read. The same fault then appears in `pc_o` or `sp_o` on the completion pulse. A wrong state transition shows as a changed cycle count between start and `done_o`.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } br_flags_t;

  typedef struct packed {
    logic       alt;
    logic       rsv;
    logic       ind;
    logic       link;
    logic [3:0] rsel;
  } br_ext_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_READ = 2'd2,
    ST_FIN  = 2'd3
  } br_state_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      alt_i,
  input  logic [2:0] sel_i,
  input  br_flags_t flags_i,
  output logic      taken_o
);
  logic sgn_eq;
  logic base_hit;
  logic alt_hit;

  assign sgn_eq = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (sel_i[2:1])
      2'd0:    base_hit = flags_i.n;
      2'd1:    base_hit = flags_i.v;
      2'd2:    base_hit = flags_i.c;
      default: base_hit = !flags_i.z;
    endcase
    // even index tests the flag clear (Z row inverted above)
    if (sel_i[2:1] == 2'd3) base_hit = base_hit ^ sel_i[0];
    else                    base_hit = base_hit ^ !sel_i[0];
  end

  always_comb begin
    unique case (sel_i)
      3'd0:    alt_hit = sgn_eq;
      3'd1:    alt_hit = !sgn_eq;
      3'd2:    alt_hit = flags_i.z || !sgn_eq;
      3'd3:    alt_hit = !flags_i.z && sgn_eq;
      3'd4:    alt_hit = !flags_i.c || flags_i.z;
      3'd5:    alt_hit = flags_i.c && !flags_i.z;
      3'd6:    alt_hit = 1'b0;
      default: alt_hit = 1'b1;
    endcase
  end

  assign taken_o = alt_i ? alt_hit : base_hit;

  p_never_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_i && sel_i == 3'd6) |-> !taken_o);
  p_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_i && sel_i == 3'd7) |-> taken_o);
  p_eq_test_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_i && sel_i == 3'd7) |-> (taken_o == flags_i.z));
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REGS*ADDR_W-1:0] regs_i,
  input  logic [SEL_W-1:0]           rsel_i,
  input  logic [ADDR_W-1:0]          offset_i,
  output logic [ADDR_W-1:0]          cur_pc_o,
  output logic [ADDR_W-1:0]          cur_sp_o,
  output logic [ADDR_W-1:0]          target_o
);
  localparam logic [SEL_W-1:0] PC_IDX = SEL_W'(NUM_REGS - 1);
  localparam logic [SEL_W-1:0] SP_IDX = SEL_W'(NUM_REGS - 2);

  logic [ADDR_W-1:0] reg_arr [NUM_REGS];
  logic [SEL_W-1:0]  base_idx;
  logic [ADDR_W-1:0] base_val;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign reg_arr[g] = regs_i[g*ADDR_W +: ADDR_W];
  end

  // zero select keeps plain PC-relative behaviour
  assign base_idx = PC_IDX ^ rsel_i;
  assign base_val = reg_arr[base_idx];
  assign target_o = base_val + offset_i;
  assign cur_pc_o = reg_arr[PC_IDX];
  assign cur_sp_o = reg_arr[SP_IDX];

  p_pc_rel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_i == '0) |-> (target_o - offset_i == cur_pc_o));
endmodule

// File: rtl/br_seq.sv
module br_seq
  import br_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  localparam int WORDS = ADDR_W / DATA_W,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              taken_i,
  input  logic              ind_i,
  input  logic              link_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] cur_sp_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORDS - 1);

  br_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              taken_q;
  logic              ind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ret_q   <= '0;
      sp_q    <= '0;
      ptr_q   <= '0;
      tgt_q   <= '0;
      taken_q <= 1'b0;
      ind_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ret_q   <= cur_pc_i;
          sp_q    <= cur_sp_i;
          ptr_q   <= target_i;
          tgt_q   <= target_i;
          taken_q <= taken_i;
          ind_q   <= ind_i;
          if (!taken_i) begin
            state_q <= ST_FIN;
          end else if (link_i) begin
            state_q <= ST_PUSH;
            idx_q   <= IDX_TOP;
          end else if (ind_i) begin
            state_q <= ST_READ;
            idx_q   <= '0;
          end else begin
            state_q <= ST_FIN;
          end
        end
        ST_PUSH: begin
          sp_q <= sp_q - 1'b1;
          if (idx_q == '0) begin
            state_q <= ind_q ? ST_READ : ST_FIN;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        ST_READ: begin
          tgt_q[idx_q*DATA_W +: DATA_W] <= mem_rdata_i;
          if (idx_q == IDX_TOP) state_q <= ST_FIN;
          else                  idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (state_q == ST_PUSH) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = sp_q;
      mem_wdata_o = ret_q[idx_q*DATA_W +: DATA_W];
    end else if (state_q == ST_READ) begin
      mem_re_o   = 1'b1;
      mem_addr_o = ptr_q + ADDR_W'(idx_q);
    end
  end

  assign done_o  = (state_q == ST_FIN);
  assign taken_o = taken_q && done_o;
  assign pc_o    = taken_q ? tgt_q : ret_q;
  assign sp_o    = sp_q;

  p_mem_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_sp_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_q == $past(sp_q) - 1'b1));
  p_no_push_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_we_o);
  p_quiet_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !taken_i) |=> (done_o && !mem_we_o && !mem_re_o));
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [2:0]                 cond_sel_i,
  input  logic [7:0]                 ext_i,
  input  logic [ADDR_W-1:0]          offset_i,
  input  logic                       flag_n_i,
  input  logic                       flag_v_i,
  input  logic                       flag_z_i,
  input  logic                       flag_c_i,
  input  logic [NUM_REGS*ADDR_W-1:0] regs_i,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic                       mem_we_o,
  output logic                       mem_re_o,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  output logic                       done_o,
  output logic                       taken_o,
  output logic [ADDR_W-1:0]          pc_o,
  output logic [ADDR_W-1:0]          sp_o
);
  localparam int SEL_W = $clog2(NUM_REGS);

  br_ext_t           ext;
  br_flags_t         flags;
  logic              cond_hit;
  logic [ADDR_W-1:0] cur_pc;
  logic [ADDR_W-1:0] cur_sp;
  logic [ADDR_W-1:0] target;

  assign ext   = br_ext_t'(ext_i);
  assign flags = '{n: flag_n_i, v: flag_v_i, z: flag_z_i, c: flag_c_i};

  br_cond_eval u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alt_i   (ext.alt),
    .sel_i   (cond_sel_i),
    .flags_i (flags),
    .taken_o (cond_hit)
  );

  br_target_gen #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_tgt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .regs_i   (regs_i),
    .rsel_i   (ext.rsel[SEL_W-1:0]),
    .offset_i (offset_i),
    .cur_pc_o (cur_pc),
    .cur_sp_o (cur_sp),
    .target_o (target)
  );

  br_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .taken_i     (cond_hit),
    .ind_i       (ext.ind),
    .link_i      (ext.link),
    .cur_pc_i    (cur_pc),
    .cur_sp_i    (cur_sp),
    .target_i    (target),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .taken_o     (taken_o),
    .pc_o        (pc_o),
    .sp_o        (sp_o)
  );

  p_ext_known_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !$isunknown({ext.rsv, ext_i}));
endmodule

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   sel = '0;
  logic [7:0]   ext = '0;
  logic [31:0]  off = '0;
  logic         fn = 0, fv = 0, fz = 0, fc = 0;
  logic [511:0] regs;
  logic [31:0]  maddr;
  logic [15:0]  mwdata;
  logic         mwe, mre;
  logic [15:0]  mrdata;
  logic         done, taken;
  logic [31:0]  pc, sp;

  always #5 clk = ~clk;

  assign mrdata = maddr[15:0] ^ 16'hA5C3;

  branch_resolver u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cond_sel_i(sel), .ext_i(ext),
    .offset_i(off), .flag_n_i(fn), .flag_v_i(fv), .flag_z_i(fz), .flag_c_i(fc),
    .regs_i(regs), .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_we_o(mwe),
    .mem_re_o(mre), .mem_rdata_i(mrdata), .done_o(done), .taken_o(taken),
    .pc_o(pc), .sp_o(sp)
  );

  int n_chk = 0;
  int n_fail = 0;

  // access log, filled at negedge
  int          w_cnt, r_cnt, evt, last_w_evt, first_r_evt;
  logic [31:0] w_addr [4];
  logic [15:0] w_data [4];
  logic [31:0] r_addr [4];

  always @(negedge clk) begin
    if (mwe) begin
      if (w_cnt < 4) begin w_addr[w_cnt] = maddr; w_data[w_cnt] = mwdata; end
      w_cnt++; evt++; last_w_evt = evt;
    end
    if (mre) begin
      if (r_cnt < 4) r_addr[r_cnt] = maddr;
      r_cnt++; evt++;
      if (first_r_evt == 0) first_r_evt = evt;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_regs(input logic [31:0] pcv, input logic [31:0] spv);
    for (int k = 0; k < 16; k++) regs[k*32 +: 32] = 32'h1000_0000 + k * 32'h111;
    regs[15*32 +: 32] = pcv;
    regs[14*32 +: 32] = spv;
  endtask

  task automatic run(input logic [2:0] s, input logic [7:0] e, input logic [31:0] o,
                     input logic [3:0] f, output int cyc);
    @(negedge clk);
    w_cnt = 0; r_cnt = 0; evt = 0; last_w_evt = 0; first_r_evt = 0;
    sel = s; ext = e; off = o; {fn, fv, fz, fc} = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {alt, sel[2:0], n, v, z, c, expected taken}
  localparam logic [8:0] VEC [16] = '{
    {1'b0, 3'd0, 4'b0000, 1'b1}, {1'b0, 3'd1, 4'b0000, 1'b0},
    {1'b0, 3'd2, 4'b0100, 1'b0}, {1'b0, 3'd3, 4'b0100, 1'b1},
    {1'b0, 3'd4, 4'b0001, 1'b0}, {1'b0, 3'd5, 4'b0001, 1'b1},
    {1'b0, 3'd6, 4'b0010, 1'b0}, {1'b0, 3'd7, 4'b0010, 1'b1},
    {1'b1, 3'd0, 4'b1000, 1'b0}, {1'b1, 3'd1, 4'b1000, 1'b1},
    {1'b1, 3'd2, 4'b0010, 1'b1}, {1'b1, 3'd3, 4'b1100, 1'b1},
    {1'b1, 3'd4, 4'b0001, 1'b0}, {1'b1, 3'd5, 4'b0001, 1'b1},
    {1'b1, 3'd6, 4'b1111, 1'b0}, {1'b1, 3'd7, 4'b0000, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    set_regs(32'h0000_4000, 32'h0000_01FF);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 done", {31'b0, done}, 32'd0);
    check("R8 we/re", {30'b0, mwe, mre}, 32'd0);
    check("R8 pc", pc, 32'd0);
    check("R8 sp", sp, 32'd0);
    rst_n = 1'b1;

    // R1/R2 condition table, PC-relative offset -16
    for (int i = 0; i < 16; i++) begin
      logic [8:0] v;
      v = VEC[i];
      run(v[7:5], {v[8], 7'b0}, 32'hFFFF_FFF0, v[4:1], cyc);
      check(v[8] ? "R2 taken" : "R1 taken", {31'b0, taken}, {31'b0, v[0]});
      check(v[8] ? "R2 pc" : "R1 pc", pc, v[0] ? 32'h0000_3FF0 : 32'h0000_4000);
      check("R7 cycles", cyc, 1);
    end

    // R3 base register 15^3 = 12
    run(3'd7, 8'b1000_0011, 32'd8, 4'b0000, cyc);
    check("R3 base reg", pc, 32'h1000_0000 + 12 * 32'h111 + 32'd8);
    check("R3 no access", w_cnt + r_cnt, 0);

    // R3 32-bit wrap of the sum
    run(3'd7, 8'b1000_0000, 32'hFFFF_B000, 4'b0000, cyc);
    check("R3 wrap", pc, 32'hFFFF_F000);

    // R5 call: push high then low word
    run(3'd7, 8'b1001_0000, 32'h20, 4'b0000, cyc);
    check("R5 writes", w_cnt, 2);
    check("R5 hi addr", w_addr[0], 32'h0000_01FF);
    check("R5 hi data", {16'b0, w_data[0]}, 32'h0000_0000);
    check("R5 lo addr", w_addr[1], 32'h0000_01FE);
    check("R5 lo data", {16'b0, w_data[1]}, 32'h0000_4000);
    check("R5 sp", sp, 32'h0000_01FD);
    check("R5 pc", pc, 32'h0000_4020);
    check("R7 call cycles", cyc, 3);
    @(negedge clk);
    check("R7 done pulse", {31'b0, done}, 32'd0);

    // R5 stack pointer crosses a page
    set_regs(32'hABCD_1234, 32'h0000_0100);
    run(3'd7, 8'b1001_0000, 32'h0, 4'b0000, cyc);
    check("R5 page hi addr", w_addr[0], 32'h0000_0100);
    check("R5 page lo addr", w_addr[1], 32'h0000_00FF);
    check("R5 page hi data", {16'b0, w_data[0]}, 32'h0000_ABCD);
    check("R5 page sp", sp, 32'h0000_00FE);

    // R4 indirect through pointer
    set_regs(32'h0000_4000, 32'h0000_01FF);
    run(3'd7, 8'b1010_0000, 32'h30, 4'b0000, cyc);
    check("R4 reads", r_cnt, 2);
    check("R4 lo addr", r_addr[0], 32'h0000_4030);
    check("R4 hi addr", r_addr[1], 32'h0000_4031);
    check("R4 target", pc, 32'hE5F2_E5F3);
    check("R4 sp kept", sp, 32'h0000_01FF);
    check("R7 ind cycles", cyc, 3);

    // R7 call through pointer: pushes before reads
    run(3'd7, 8'b1011_0000, 32'h30, 4'b0000, cyc);
    check("R7 both cycles", cyc, 5);
    check("R7 order", {31'b0, (last_w_evt == 2 && first_r_evt == 3)}, 32'd1);
    check("R4 both target", pc, 32'hE5F2_E5F3);
    check("R5 both sp", sp, 32'h0000_01FD);

    // R6 not taken with link and indirect requested
    run(3'd7, 8'b0011_0000, 32'h30, 4'b0000, cyc);
    check("R6 cycles", cyc, 1);
    check("R6 no access", w_cnt + r_cnt, 0);
    check("R6 taken", {31'b0, taken}, 32'd0);
    check("R6 pc", pc, 32'h0000_4000);
    check("R6 sp", sp, 32'h0000_01FF);

    // R2 never with link set: no push
    run(3'd6, 8'b1001_0000, 32'h10, 4'b0000, cyc);
    check("R2 never quiet", w_cnt, 0);
    check("R2 never sp", sp, 32'h0000_01FF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule